// File: doc/BRIEF.md
# Compressed Register-Pair Load/Store Expander

This block sits in a 32-bit instruction decoder. It widens four 16-bit encodings that move a pair of 32-bit integer registers to or from memory into the equivalent 32-bit doubleword load or store. Two of the forms use the stack pointer (x2) as base and take any data register. The other two take a base and a data register from the compact x8..x15 set. Every offset is unsigned and counted in units of eight bytes. The data register names the even half of a pair, so an odd data register is reserved. An input selects how that case is reported: either as an illegal instruction or on a separate fatal flag.

The expander has one register stage. Each output shows the decode of the halfword presented one clock earlier. When the pair extension is switched off, when the build is not 32-bit, or when the halfword is not one of the four forms, every output is zero. The surrounding decoder then handles that halfword. The same opcode slots carry compressed single-precision float loads and stores in other configurations, so the enable must stay low whenever those are in use.

Top module: `cpair_expand`

## Requirements
- R1: Outputs are registered. The values seen after a clock edge come from the inputs sampled at that edge. While rst_n is low, exp_instr_o, hit_o, illegal_o and fatal_o are all 0.
- R2: hit_o is 1 only when pair_en_i is 1, XLEN is 32, bits [15:13] are 011 or 111, and bits [1:0] are 00 or 10. Otherwise hit_o, illegal_o, fatal_o and exp_instr_o are all 0.
- R3: The stack load (bits [15:13]=011, [1:0]=10) expands to an I-type load: imm[11:0] = zero-extended {c[4:2], c[12], c[6:5], 000}, rs1 = x2, funct3 = 011, rd = c[11:7], opcode = 0000011. Example: 0x6442 gives 0x01013403.
- R4: The stack store (bits [15:13]=111, [1:0]=10) expands to an S-type store with offset {c[9:7], c[12:10], 000}, rs2 = c[6:2], rs1 = x2, funct3 = 011, opcode = 0100011. The offset is split as imm[11:5] in [31:25] and imm[4:0] in [11:7]. Example: 0xE822 gives 0x00813823.
- R5: The register load (bits [15:13]=011, [1:0]=00) expands to an I-type load with offset {c[6:5], c[12:10], 000}, rs1 = 8 + c[9:7], rd = 8 + c[4:2]. Example: 0x6008 gives 0x00043503.
- R6: The register store (bits [15:13]=111, [1:0]=00) expands to an S-type store with the same offset layout as R5, rs1 = 8 + c[9:7], rs2 = 8 + c[4:2]. Example: 0xE008 gives 0x00A43023.
- R7: An odd data register (bit 0 of the 5-bit register number) is reserved. If odd_fatal_i is 0, illegal_o is 1 and fatal_o is 0. If odd_fatal_i is 1, fatal_o is 1 and illegal_o is 0.
- R8: A stack load with rd = x0 sets illegal_o, whichever odd-register policy is selected.
- R9: When illegal_o or fatal_o is 1, hit_o is 1 and exp_instr_o is 0. illegal_o and fatal_o are never 1 together.
- R10: A stack store whose source register is x0 is legal and expands normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cinstr_i | input | 16 | Compressed halfword to expand |
| pair_en_i | input | 1 | Compressed pair extension enabled |
| odd_fatal_i | input | 1 | Odd-register policy: 0 reports illegal, 1 reports fatal |
| exp_instr_o | output | 32 | Expanded 32-bit instruction, zero when not produced |
| hit_o | output | 1 | Halfword was one of the four pair forms |
| illegal_o | output | 1 | Matched form with a reserved or invalid register |
| fatal_o | output | 1 | Odd data register under the fatal policy |

## Verification
All state is a single output register, so a wrong stored value appears on the ports in the cycle after the halfword that caused it and persists for no more than that one cycle. A wrong form classification shows up as a wrong hit_o. A wrong field mapping shows up as a misplaced register number or offset bit in exp_instr_o. A wrong legality decision shows up as a wrong flag, and it also leaves a nonzero or zero expansion where the opposite is expected. Random halfwords are biased toward the four opcode slots and compared each cycle against a reference model. The four known encodings, x0 and odd-register cases, and the enable and policy inputs are also applied directly.

// File: rtl/cpair_pkg.sv
package cpair_pkg;

    typedef enum logic [2:0] {
        FORM_NONE  = 3'd0,
        FORM_SP_LD = 3'd1,
        FORM_SP_ST = 3'd2,
        FORM_RG_LD = 3'd3,
        FORM_RG_ST = 3'd4
    } form_e;

    localparam logic [6:0] OPC_LOAD    = 7'b0000011;
    localparam logic [6:0] OPC_STORE   = 7'b0100011;
    localparam logic [2:0] FUNCT3_PAIR = 3'b011;
    localparam logic [2:0] CF3_LOAD    = 3'b011;
    localparam logic [2:0] CF3_STORE   = 3'b111;
    localparam logic [1:0] QUAD_REG    = 2'b00;
    localparam logic [1:0] QUAD_SP     = 2'b10;
    localparam logic [4:0] REG_SP      = 5'd2;
    localparam logic [4:0] REG_ZERO    = 5'd0;

    typedef struct packed {
        logic [31:0] instr;
        logic        hit;
        logic        illegal;
        logic        fatal;
    } exp_out_t;

endpackage

// File: rtl/cpair_classify.sv
module cpair_classify
    import cpair_pkg::*;
(
    input  logic       enable_i,
    input  logic [2:0] cf3_i,
    input  logic [1:0] quad_i,
    output form_e      form_o
);
    always_comb begin
        form_o = FORM_NONE;
        if (enable_i) begin
            unique case ({quad_i, cf3_i})
                {QUAD_SP,  CF3_LOAD}:  form_o = FORM_SP_LD;
                {QUAD_SP,  CF3_STORE}: form_o = FORM_SP_ST;
                {QUAD_REG, CF3_LOAD}:  form_o = FORM_RG_LD;
                {QUAD_REG, CF3_STORE}: form_o = FORM_RG_ST;
                default:               form_o = FORM_NONE;
            endcase
        end
    end
endmodule

// File: rtl/cpair_fields.sv
module cpair_fields
    import cpair_pkg::*;
#(
    parameter int RW = 5,
    parameter int IW = 12,
    parameter int CRW = 3
) (
    input  form_e           form_i,
    input  logic [12:2]     body_i,
    output logic [RW-1:0]   data_reg_o,
    output logic [RW-1:0]   base_reg_o,
    output logic [IW-1:0]   imm_o,
    output logic            is_store_o
);
    localparam int PAD = RW - CRW;
    localparam logic [PAD-1:0] CREG_HI = {1'b0, {(PAD-1){1'b1}}};

    logic [RW-1:0] creg_base;
    logic [RW-1:0] creg_data;
    logic [8:0]    sp_ld_off;
    logic [8:0]    sp_st_off;
    logic [7:0]    rg_off;

    always_comb begin
        creg_base = {CREG_HI, body_i[9:7]};
        creg_data = {CREG_HI, body_i[4:2]};
        sp_ld_off = {body_i[4:2], body_i[12], body_i[6:5], 3'b000};
        sp_st_off = {body_i[9:7], body_i[12:10], 3'b000};
        rg_off    = {body_i[6:5], body_i[12:10], 3'b000};

        data_reg_o = '0;
        base_reg_o = '0;
        imm_o      = '0;
        is_store_o = 1'b0;
        unique case (form_i)
            FORM_SP_LD: begin
                data_reg_o = body_i[11:7];
                base_reg_o = REG_SP;
                imm_o      = IW'(sp_ld_off);
            end
            FORM_SP_ST: begin
                data_reg_o = body_i[6:2];
                base_reg_o = REG_SP;
                imm_o      = IW'(sp_st_off);
                is_store_o = 1'b1;
            end
            FORM_RG_LD: begin
                data_reg_o = creg_data;
                base_reg_o = creg_base;
                imm_o      = IW'(rg_off);
            end
            FORM_RG_ST: begin
                data_reg_o = creg_data;
                base_reg_o = creg_base;
                imm_o      = IW'(rg_off);
                is_store_o = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cpair_legal.sv
module cpair_legal
    import cpair_pkg::*;
#(
    parameter int RW = 5
) (
    input  form_e         form_i,
    input  logic [RW-1:0] data_reg_i,
    input  logic          odd_fatal_i,
    output logic          illegal_o,
    output logic          fatal_o
);
    logic odd_reg;
    logic sp_ld_zero;

    always_comb begin
        odd_reg    = data_reg_i[0];
        sp_ld_zero = (form_i == FORM_SP_LD) && (data_reg_i == REG_ZERO);
        illegal_o  = 1'b0;
        fatal_o    = 1'b0;
        if (form_i != FORM_NONE) begin
            if (odd_reg) begin
                illegal_o = !odd_fatal_i;
                fatal_o   = odd_fatal_i;
            end else if (sp_ld_zero) begin
                illegal_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cpair_assemble.sv
module cpair_assemble
    import cpair_pkg::*;
#(
    parameter int RW = 5,
    parameter int IW = 12,
    parameter int EW = 32
) (
    input  logic          is_store_i,
    input  logic [RW-1:0] data_reg_i,
    input  logic [RW-1:0] base_reg_i,
    input  logic [IW-1:0] imm_i,
    output logic [EW-1:0] instr_o
);
    always_comb begin
        if (is_store_i) begin
            instr_o = {imm_i[11:5], data_reg_i, base_reg_i, FUNCT3_PAIR,
                       imm_i[4:0], OPC_STORE};
        end else begin
            instr_o = {imm_i, base_reg_i, FUNCT3_PAIR, data_reg_i, OPC_LOAD};
        end
    end
endmodule

// File: rtl/cpair_expand.sv
module cpair_expand
    import cpair_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CW   = 16,
    parameter int EW   = 32,
    parameter int RW   = 5,
    parameter int IW   = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cinstr_i,
    input  logic          pair_en_i,
    input  logic          odd_fatal_i,
    output logic [EW-1:0] exp_instr_o,
    output logic          hit_o,
    output logic          illegal_o,
    output logic          fatal_o
);
    localparam bit PAIR_BUILD = (XLEN == 32);

    logic          en_eff;
    form_e         form;
    logic [RW-1:0] data_reg;
    logic [RW-1:0] base_reg;
    logic [IW-1:0] imm;
    logic          is_store;
    logic          bad_illegal;
    logic          bad_fatal;
    logic [EW-1:0] asm_instr;
    exp_out_t      out_d;
    exp_out_t      out_q;

    generate
        if (PAIR_BUILD) begin : g_rv32
            assign en_eff = pair_en_i;
        end else begin : g_other
            assign en_eff = 1'b0;
        end
    endgenerate

    cpair_classify u_classify (
        .enable_i (en_eff),
        .cf3_i    (cinstr_i[15:13]),
        .quad_i   (cinstr_i[1:0]),
        .form_o   (form)
    );

    cpair_fields #(.RW(RW), .IW(IW)) u_fields (
        .form_i     (form),
        .body_i     (cinstr_i[12:2]),
        .data_reg_o (data_reg),
        .base_reg_o (base_reg),
        .imm_o      (imm),
        .is_store_o (is_store)
    );

    cpair_legal #(.RW(RW)) u_legal (
        .form_i      (form),
        .data_reg_i  (data_reg),
        .odd_fatal_i (odd_fatal_i),
        .illegal_o   (bad_illegal),
        .fatal_o     (bad_fatal)
    );

    cpair_assemble #(.RW(RW), .IW(IW), .EW(EW)) u_assemble (
        .is_store_i (is_store),
        .data_reg_i (data_reg),
        .base_reg_i (base_reg),
        .imm_i      (imm),
        .instr_o    (asm_instr)
    );

    always_comb begin
        out_d = '0;
        if (form != FORM_NONE) begin
            out_d.hit     = 1'b1;
            out_d.illegal = bad_illegal;
            out_d.fatal   = bad_fatal;
            out_d.instr   = (bad_illegal || bad_fatal) ? '0 : asm_instr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign exp_instr_o = out_q.instr;
    assign hit_o       = out_q.hit;
    assign illegal_o   = out_q.illegal;
    assign fatal_o     = out_q.fatal;

    // R2: a disabled extension yields no hit one cycle later
    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_en_i |=> (!hit_o && !illegal_o && !fatal_o && exp_instr_o == '0));

    // R7: the illegal policy never raises fatal
    a_r7_policy_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        !odd_fatal_i |=> !fatal_o);

    // R9: flags are exclusive and imply a hit with zero expansion
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(illegal_o && fatal_o));

    a_r9_flag_zero_instr: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_o || fatal_o) |-> (hit_o && exp_instr_o == '0));

    // R3: an emitted expansion always carries the pair funct3 and a load/store opcode
    a_r3_opcode_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && !illegal_o && !fatal_o) |->
        (exp_instr_o[14:12] == FUNCT3_PAIR &&
         (exp_instr_o[6:0] == OPC_LOAD || exp_instr_o[6:0] == OPC_STORE)));

    // R2: no hit means an all-zero expansion
    a_r2_nohit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (exp_instr_o == '0 && !illegal_o && !fatal_o));

    // R1: outputs follow the input halfword's quadrant one cycle later
    a_r1_registered: assert property (@(posedge clk) disable iff (!rst_n)
        (cinstr_i[1:0] == 2'b11) |=> !hit_o);
endmodule

// File: tb/cpair_expand_tb.sv
module cpair_expand_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cinstr = '0;
    logic        pair_en = 1'b0;
    logic        odd_fatal = 1'b0;
    logic [31:0] exp_instr;
    logic        hit;
    logic        illegal;
    logic        fatal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpair_expand u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cinstr_i    (cinstr),
        .pair_en_i   (pair_en),
        .odd_fatal_i (odd_fatal),
        .exp_instr_o (exp_instr),
        .hit_o       (hit),
        .illegal_o   (illegal),
        .fatal_o     (fatal)
    );

    // reference model: {instr, hit, illegal, fatal}
    function automatic logic [34:0] ref_model(input logic [15:0] c, input logic en,
                                              input logic pol);
        logic [4:0]  rd, rs1;
        logic [11:0] off;
        logic        st, hitv, ill, fat;
        logic [31:0] w;
        hitv = 0; ill = 0; fat = 0; w = 0; st = 0; rd = 0; rs1 = 0; off = 0;
        if (en && (c[15:13] == 3'b011 || c[15:13] == 3'b111) &&
            (c[1:0] == 2'b00 || c[1:0] == 2'b10)) begin
            hitv = 1;
            st = c[15];
            if (c[1:0] == 2'b10) begin
                rs1 = 5'd2;
                if (!st) begin
                    rd  = c[11:7];
                    off = {3'b0, c[4:2], c[12], c[6:5], 3'b0};
                end else begin
                    rd  = c[6:2];
                    off = {3'b0, c[9:7], c[12:10], 3'b0};
                end
            end else begin
                rs1 = {2'b01, c[9:7]};
                rd  = {2'b01, c[4:2]};
                off = {4'b0, c[6:5], c[12:10], 3'b0};
            end
            if (rd[0]) begin
                if (pol) fat = 1; else ill = 1;
            end else if (!st && c[1:0] == 2'b10 && rd == 0) begin
                ill = 1;
            end
            if (!ill && !fat) begin
                if (st) w = {off[11:5], rd, rs1, 3'b011, off[4:0], 7'b0100011};
                else    w = {off, rs1, 3'b011, rd, 7'b0000011};
            end
        end
        return {w, hitv, ill, fat};
    endfunction

    function automatic string tag_of(input logic [15:0] c, input logic en);
        if (!en || !((c[15:13] == 3'b011 || c[15:13] == 3'b111) &&
                     (c[1:0] == 2'b00 || c[1:0] == 2'b10))) return "R2";
        if (c[1:0] == 2'b10) return c[15] ? "R4" : "R3";
        return c[15] ? "R6" : "R5";
    endfunction

    task automatic check(input string req, input logic [34:0] expv);
        checks++;
        if ({exp_instr, hit, illegal, fatal} !== expv) begin
            errors++;
            $display("FAIL %s: got instr=%h hit=%b ill=%b fat=%b, expected instr=%h hit=%b ill=%b fat=%b",
                     req, exp_instr, hit, illegal, fatal,
                     expv[34:3], expv[2], expv[1], expv[0]);
        end
    endtask

    task automatic apply(input logic [15:0] c, input logic en, input logic pol,
                         input string req);
        @(negedge clk);
        cinstr = c; pair_en = en; odd_fatal = pol;
        @(negedge clk);
        check(req, ref_model(c, en, pol));
    endtask

    task automatic apply_lit(input logic [15:0] c, input logic [31:0] w, input string req);
        @(negedge clk);
        cinstr = c; pair_en = 1; odd_fatal = 0;
        @(negedge clk);
        check(req, {w, 1'b1, 1'b0, 1'b0});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset clears outputs even with a matching input
        cinstr = 16'h6008; pair_en = 1;
        repeat (3) @(negedge clk);
        check("R1", 35'd0);
        rst_n = 1;

        // R3..R6: known encodings
        apply_lit(16'h6442, 32'h01013403, "R3");
        apply_lit(16'hE822, 32'h00813823, "R4");
        apply_lit(16'h6008, 32'h00043503, "R5");
        apply_lit(16'hE008, 32'h00A43023, "R6");

        // R1: output holds until the next edge after an input change
        @(negedge clk);
        cinstr = 16'h0001; pair_en = 1;
        #1;
        check("R1", {32'h00A43023, 3'b100});
        @(negedge clk);
        check("R1", 35'd0);

        // R2: disabled extension ignores a matching form
        apply(16'h6442, 1'b0, 1'b0, "R2");
        apply(16'h6443, 1'b1, 1'b0, "R2");
        apply(16'h4442, 1'b1, 1'b0, "R2");

        // R7: odd data register under each policy
        apply(16'h64C2, 1'b1, 1'b0, "R7");
        apply(16'h64C2, 1'b1, 1'b1, "R7");
        apply(16'hE00C, 1'b1, 1'b1, "R7");
        apply(16'h600C, 1'b1, 1'b0, "R7");

        // R8: stack load into x0, both policies
        apply(16'h6002, 1'b1, 1'b0, "R8");
        apply(16'h6002, 1'b1, 1'b1, "R8");

        // R10: stack store from x0 with max offset
        apply(16'hFF82, 1'b1, 1'b0, "R10");

        // R9: large offsets and stack-load full range
        apply(16'h7FFE, 1'b1, 1'b1, "R9");
        apply(16'h7F7E, 1'b1, 1'b0, "R3");

        // random stimulus biased to the pair slots
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] c;
            logic en, pol;
            c = 16'($urandom);
            if ($urandom_range(0, 3) != 0) begin
                c[15:13] = $urandom_range(0, 1) ? 3'b011 : 3'b111;
                c[1:0]   = $urandom_range(0, 1) ? 2'b10 : 2'b00;
            end
            en  = ($urandom_range(0, 7) != 0);
            pol = 1'($urandom);
            apply(c, en, pol, tag_of(c, en));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule